// File: doc/BRIEF.md
# Receive FIFO Read Formatter

This block turns a stream of received packets into the 32-bit words a host reads. Packet bytes come from a show-ahead data FIFO, four bytes to a word. Each packet's length comes from a separate status FIFO. The status FIFO may hold several entries ahead of the data.

On every host read the block produces one output word. For each packet it first inserts a programmable number of zero filler bytes. It then places the packet bytes, and finally, when padding is on, appends zero words so that the packet's word count is a whole multiple of the host burst length. Offset and padding are applied afresh to every packet, so packets read back-to-back keep their boundaries.

A host read that asks for data the FIFOs do not hold is an underrun. The block then raises a sticky error and stops following the stream until it is reset.

Top module: `rx_read_formatter`

## Requirements
- R1: The data FIFO holds each packet packed little-endian: packet byte k sits in lane k mod 4 (bits 8*lane+7 down to 8*lane) of the packet's FIFO word k div 4, and every packet starts in a fresh FIFO word. For a packet with offset `off` and length `len`, host word j (counting from 0 at the packet's first read) carries in lane b packet byte 4j+b-off when that index lies in [0, len), and zero otherwise.
- R2: The offset (0 to 31 bytes) is sampled from `cfg_offset` on the first host read of a packet. Changing `cfg_offset` later in the packet has no effect on that packet.
- R3: With padding off, a packet takes exactly ceil((off+len)/4) host reads. The next read then starts the next packet.
- R4: With padding on, the word count from R3 is rounded up to a multiple of the burst length; a `cfg_burst` of 0 counts as 1. `cfg_pad_en` and `cfg_burst` are sampled on the packet's first read, like the offset.
- R5: Each packet consumes exactly one status word, popped on its first read, and exactly ceil(len/4) data words. Packets read back-to-back each receive their own offset and padding.
- R6: After reset, `rd_data` is zero, `rx_err` is low, and neither FIFO is popped until a read arrives.
- R7: A read is an underrun when it starts a packet while the status FIFO is empty, or when it needs a data word while the data FIFO is empty. An underrun sets `rx_err`, returns zero on `rd_data`, and pops nothing.
- R8: Once `rx_err` is set, every read returns zero and pops nothing, and `rx_err` stays high until reset. Reset clears `rx_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also the recovery after an underrun |
| cfg_offset | input | OFF_W | Leading filler bytes per packet |
| cfg_pad_en | input | 1 | Enables trailing burst-alignment padding |
| cfg_burst | input | BURST_W | Host burst length in words (0 treated as 1) |
| sts_valid | input | 1 | Status FIFO is not empty |
| sts_len | input | LEN_W | Packet length in bytes at the status FIFO head |
| sts_pop | output | 1 | Pops the status FIFO head |
| dat_valid | input | 1 | Data FIFO is not empty |
| dat_word | input | 32 | Data FIFO head word (show-ahead) |
| dat_pop | output | 1 | Pops the data FIFO head |
| rd_en | input | 1 | Host read strobe, one word per cycle |
| rd_data | output | 32 | Word for the host, registered, valid the cycle after `rd_en` |
| rx_err | output | 1 | Sticky underrun error |

## Verification
A wrong byte position, a stale previous-word register or a miscounted offset shows up as a wrong lane value on the very next `rd_data` word. A wrong end-of-packet decision shows up differently: the FIFO pop counts drift from the expected totals, and every word of the following packet is shifted, so the error is visible within one packet. A missed or spurious underrun shows on `rx_err` one cycle after the offending read, and from then on every read returns zero.

// File: rtl/rx_read_formatter.sv
module rx_read_formatter #(
  parameter int LEN_W   = 14,
  parameter int OFF_W   = 5,
  parameter int BURST_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OFF_W-1:0]   cfg_offset,
  input  logic               cfg_pad_en,
  input  logic [BURST_W-1:0] cfg_burst,
  input  logic               sts_valid,
  input  logic [LEN_W-1:0]   sts_len,
  output logic               sts_pop,
  input  logic               dat_valid,
  input  logic [31:0]        dat_word,
  output logic               dat_pop,
  input  logic               rd_en,
  output logic [31:0]        rd_data,
  output logic               rx_err
);
  localparam int PW = LEN_W + 3;
  localparam logic signed [PW-1:0] THREE = PW'(3);
  localparam logic signed [PW-1:0] FOUR  = PW'(4);

  logic                  busy;
  logic signed [PW-1:0]  pos_q;
  logic [LEN_W-1:0]      len_q;
  logic                  pad_q;
  logic [BURST_W-1:0]    bm1_q, bcnt_q;
  logic [31:0]           prev_q;

  logic signed [PW-1:0]  off_ext, pos_c, len_ext, hi, len4;
  logic [LEN_W-1:0]      len_c;
  logic                  pad_c, need, last_data, done, underrun, take;
  logic [BURST_W-1:0]    bm1_c, bcnt_c, cfg_bm1;
  logic [63:0]           combo;
  logic [31:0]           word_c;

  assign off_ext = $signed({{(PW-OFF_W){1'b0}}, cfg_offset});
  assign cfg_bm1 = (cfg_burst == '0) ? '0 : cfg_burst - BURST_W'(1);
  assign pos_c   = busy ? pos_q  : -off_ext;
  assign len_c   = busy ? len_q  : sts_len;
  assign pad_c   = busy ? pad_q  : cfg_pad_en;
  assign bm1_c   = busy ? bm1_q  : cfg_bm1;
  assign bcnt_c  = busy ? bcnt_q : '0;
  assign len_ext = $signed({3'b000, len_c});
  assign hi      = pos_c + THREE;
  assign len4    = ((len_ext + THREE) >>> 2) <<< 2;
  assign need    = (hi >= 0) && (hi < len4);
  assign last_data = (pos_c + FOUR) >= len_ext;
  assign done    = last_data && (!pad_c || (bcnt_c == bm1_c));
  assign combo   = {dat_word, prev_q};

  always_comb begin
    word_c = '0;
    for (int b = 0; b < 4; b++) begin
      logic signed [PW-1:0] p;
      logic [2:0] idx;
      p   = pos_c + PW'(b);
      idx = {1'b0, hi[1:0]} + 3'(b) + 3'd1;
      if (p >= 0 && p < len_ext)
        word_c[8*b +: 8] = combo[{idx, 3'b000} +: 8];
    end
  end

  assign underrun = rd_en && !rx_err && ((!busy && !sts_valid) || (need && !dat_valid));
  assign take     = rd_en && !rx_err && !underrun;
  assign sts_pop  = take && !busy;
  assign dat_pop  = take && need;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      pos_q   <= '0;
      len_q   <= '0;
      pad_q   <= 1'b0;
      bm1_q   <= '0;
      bcnt_q  <= '0;
      prev_q  <= '0;
      rd_data <= '0;
      rx_err  <= 1'b0;
    end else if (take) begin
      rd_data <= word_c;
      busy    <= !done;
      pos_q   <= pos_c + FOUR;
      len_q   <= len_c;
      pad_q   <= pad_c;
      bm1_q   <= bm1_c;
      bcnt_q  <= (bcnt_c == bm1_c) ? '0 : bcnt_c + BURST_W'(1);
      if (need) prev_q <= dat_word;
    end else if (rd_en) begin
      rd_data <= '0;
      if (underrun) rx_err <= 1'b1;
    end
  end
endmodule

module rx_read_formatter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic        sts_valid,
  input logic        dat_valid,
  input logic        sts_pop,
  input logic        dat_pop,
  input logic        busy,
  input logic        rx_err,
  input logic [31:0] rd_data
);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |=> rx_err);
  p_zero_after_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err && rd_en |=> rd_data == 32'd0);
  p_no_pop_after_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> !sts_pop && !dat_pop);
  p_empty_status_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rx_err && !busy && !sts_valid |=> rx_err && rd_data == 32'd0);
  p_pop_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_pop || dat_pop) |-> rd_en);
  p_status_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sts_pop |-> !busy && sts_valid);
  p_data_present_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dat_pop |-> dat_valid);
endmodule

bind rx_read_formatter rx_read_formatter_chk u_chk (.*);

// File: tb/rx_read_formatter_bench.sv
`timescale 1ns/1ps
module rx_read_formatter_bench;
  localparam int LEN_W = 14, OFF_W = 5, BURST_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [OFF_W-1:0] cfg_offset = '0;
  logic cfg_pad_en = 1'b0;
  logic [BURST_W-1:0] cfg_burst = '0;
  logic sts_valid, sts_pop, dat_valid, dat_pop, rx_err;
  logic [LEN_W-1:0] sts_len;
  logic [31:0] dat_word, rd_data;
  logic rd_en = 1'b0;

  logic [31:0] dmem [64];
  int          smem [16];
  int          sid  [16];
  int dwr = 0, drd = 0, swr = 0, srd = 0, pk_w = 0;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  assign dat_valid = drd < dwr;
  assign dat_word  = dmem[drd % 64];
  assign sts_valid = srd < swr;
  assign sts_len   = LEN_W'(smem[srd % 16]);

  always @(posedge clk) begin
    if (dat_pop) drd <= drd + 1;
    if (sts_pop) srd <= srd + 1;
  end

  rx_read_formatter #(.LEN_W(LEN_W), .OFF_W(OFF_W), .BURST_W(BURST_W)) u_rx_read_formatter (
    .clk(clk), .rst_n(rst_n), .cfg_offset(cfg_offset), .cfg_pad_en(cfg_pad_en),
    .cfg_burst(cfg_burst), .sts_valid(sts_valid), .sts_len(sts_len), .sts_pop(sts_pop),
    .dat_valid(dat_valid), .dat_word(dat_word), .dat_pop(dat_pop), .rd_en(rd_en),
    .rd_data(rd_data), .rx_err(rx_err));

  function automatic logic [7:0] pbyte(int id, int p);
    return 8'((id * 37 + p * 11 + 5) ^ (p >> 3));
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_packet(int len, bit with_data);
    smem[swr % 16] = len;
    sid[swr % 16]  = pk_w;
    swr++;
    if (with_data)
      for (int w = 0; w < (len + 3) / 4; w++) begin
        logic [31:0] v;
        v = '0;
        for (int b = 0; b < 4; b++)
          if (4 * w + b < len) v[8*b +: 8] = pbyte(pk_w, 4 * w + b);
        dmem[dwr % 64] = v;
        dwr++;
      end
    pk_w++;
  endtask

  task automatic host_read(output logic [31:0] w);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    w = rd_data;
  endtask

  task automatic do_reset();
    rd_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_packet(int off, bit pad, int burst, string tag);
    int len, id, t, b1, s0, d0;
    logic [31:0] w, e;
    len = smem[srd % 16];
    id  = sid[srd % 16];
    s0  = srd;
    d0  = drd;
    b1  = (burst == 0) ? 1 : burst;
    t   = (off + len + 3) / 4;
    if (pad) t = ((t + b1 - 1) / b1) * b1;
    cfg_offset = OFF_W'(off);
    cfg_pad_en = pad;
    cfg_burst  = BURST_W'(burst);
    for (int j = 0; j < t; j++) begin
      host_read(w);
      if (j == 0) begin
        cfg_offset = OFF_W'(off + 13);
        cfg_pad_en = !pad;
        cfg_burst  = BURST_W'(burst + 3);
      end
      e = '0;
      for (int b = 0; b < 4; b++) begin
        int p;
        p = 4 * j + b - off;
        if (p >= 0 && p < len) e[8*b +: 8] = pbyte(id, p);
      end
      check(w === e, {tag, " R1 R2 word"}, w, e);
    end
    check(srd == s0 + 1, {tag, " R5 status pops"}, 32'(srd - s0), 32'd1);
    check(drd == d0 + (len + 3) / 4, {tag, " R3 R4 R5 data pops"}, 32'(drd - d0),
          32'((len + 3) / 4));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    int bl [4];
    logic [31:0] w;
    bl = '{1, 2, 4, 5};
    @(negedge clk);
    @(negedge clk);
    check(rd_data === 32'd0, "R6 rd_data in reset", rd_data, 32'd0);
    check(rx_err === 1'b0, "R6 rx_err in reset", 32'(rx_err), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(rd_data === 32'd0 && rx_err === 1'b0, "R6 after reset", rd_data, 32'd0);
    check(srd == 0 && drd == 0, "R6 no pops", 32'(srd + drd), 32'd0);

    for (int pad = 0; pad < 2; pad++)
      for (int bi = 0; bi < 4; bi++)
        for (int off = 0; off < 32; off++) begin
          for (int len = 1; len <= 12; len++) push_packet(len, 1'b1);
          for (int k = 0; k < 12; k++)
            read_packet(off, pad[0], bl[bi], pad ? "pad" : "nopad");
        end
    check(rx_err === 1'b0, "R7 no error in sweep", 32'(rx_err), 32'd0);

    push_packet(40, 1'b1);
    push_packet(3, 1'b1);
    read_packet(31, 1'b1, 16, "long R4");
    read_packet(0, 1'b1, 0, "burst0 R4");

    host_read(w);
    check(w === 32'd0, "R7 empty status data", w, 32'd0);
    check(rx_err === 1'b1, "R7 empty status err", 32'(rx_err), 32'd1);
    push_packet(8, 1'b1);
    for (int k = 0; k < 3; k++) begin
      host_read(w);
      check(w === 32'd0 && rx_err === 1'b1, "R8 read after error", w, 32'd0);
    end
    check(srd == swr - 1 && drd == dwr - 2, "R8 no pops after error", 32'(srd), 32'(swr - 1));
    do_reset();
    check(rx_err === 1'b0, "R8 reset clears", 32'(rx_err), 32'd0);
    read_packet(2, 1'b0, 1, "resync R5");

    push_packet(5, 1'b0);
    cfg_offset = 5'd8;
    cfg_pad_en = 1'b0;
    host_read(w);
    check(w === 32'd0 && rx_err === 1'b0, "R7 leading filler word 0", w, 32'd0);
    host_read(w);
    check(w === 32'd0 && rx_err === 1'b0, "R7 leading filler word 1", w, 32'd0);
    host_read(w);
    check(rx_err === 1'b1, "R7 missing data err", 32'(rx_err), 32'd1);
    check(w === 32'd0, "R7 missing data zero", w, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule